// File: doc/BRIEF.md
# PHY Management Serial Controller

This block lets a host reach the management registers of an external Ethernet PHY over the two-wire management interface (MDC clock, bidirectional MDIO data). The host writes the PHY address and register number, plus a data word for writes, through a small word-indexed register port. It then raises a start bit. The controller runs one clause-22 frame: 32 preamble ones, the start pattern, the opcode, both addresses, the turnaround and 16 data bits. After a read frame, the captured PHY data can be read from a register.

MDC is derived from the system clock. Each half period of MDC lasts `div+1` clock cycles, where `div` is a 4-bit field of the configuration register. The divider is taken when a frame starts, so a frame always runs at one rate. The start bit is level-style. Once a frame has begun, another one can begin only after the host has written the start bit back to 0. A rise of the start bit that arrives while a frame is running is held and served as soon as the engine becomes idle.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, the busy flag is 0, MDC is low, MDIO is released (`mdio_oe`=0), the configuration register reads 0x34 (divider 13 in bits 5:2), and the read-data register reads 0.
- R2: Register map by word index, with unlisted bits reading 0:
  - 0 is the command register: bit 0 is start, bit 1 is direction (1 = write).
  - 1 is the address register: PHY address in bits 12:8, register number in bits 4:0.
  - 2 is the write-data register, bits 15:0.
  - 3 is the read-data register, bits 15:0, read-only; host writes to it are ignored.
  - 4 is the configuration register: divider in bits 5:2.
  - 5 is the status register: bit 0 is busy.
- R3: A frame starts on the clock edge after one at which the start bit is 1, the engine is idle and the start is armed. Busy is 1 from the cycle after that edge for exactly 128*(div+1) cycles.
- R4: During a frame, every one of the 64 bits holds MDC low for div+1 cycles and then high for div+1 cycles. MDC is low while idle.
- R5: The driven bit sequence is:
  - 32 ones, then 0 1;
  - the opcode, 1 0 for read or 0 1 for write;
  - the PHY address, MSB first, then the register number, MSB first;
  - for a write, turnaround 1 0 and then the write data, MSB first.
  MDIO changes only while MDC is low.
- R6: For a read frame, MDIO is released during bits 46 to 63 (turnaround and data). It is also released while idle.
- R7: A read frame samples `mdio_i` at the rising MDC edge of bits 48 to 63, MSB first. The result is stored in the read-data register in the cycle busy falls. The read-data register does not change during a frame, and write frames leave it unchanged.
- R8: After a frame starts, no new frame starts until the start bit has been seen at 0. If the start bit is lowered and raised again during a frame, the next frame starts after exactly one idle cycle.
- R9: The divider and frame fields are captured at the start of a frame. Host writes during a frame affect only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register word index |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational on host_addr) |
| mdc | output | 1 | Management clock to PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (0 = high impedance) |
| mdio_i | input | 1 | MDIO input value |

## Verification
Two things can fall into the same clock cycle: the end of a frame, and a pending start that the host lowered and raised again while the frame was running. The bench provokes this by toggling the start bit in mid-frame, so the queued start meets the cycle in which busy falls. The cycle-accurate reference model requires busy to drop for exactly one cycle, the captured read data to land in that idle cycle, and the next frame to begin right after it. A second collision is a divider write landing inside a running frame. It is judged by counting the MDC high cycles of that frame against the divider captured at its start.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_LEN = 64;
    localparam int DATA_BITS = 16;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int REG_AW    = 3;

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(46);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(48);

    typedef enum logic [REG_AW-1:0] {
        SEL_CMD   = 3'd0,
        SEL_ADDR  = 3'd1,
        SEL_WDATA = 3'd2,
        SEL_RDATA = 3'd3,
        SEL_CFG   = 3'd4,
        SEL_STAT  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic                 wr;
        logic [4:0]           phy;
        logic [4:0]           regn;
        logic [DATA_BITS-1:0] wdata;
    } mgmt_req_t;

    typedef struct packed {
        logic oe;
        logic o;
    } pin_t;

    // Value and drive of MDIO for one bit slot of a clause-22 frame.
    function automatic pin_t frame_pin(input logic [IDX_W-1:0] idx, input mgmt_req_t r);
        pin_t p;
        int   k;
        k    = int'(idx);
        p.oe = 1'b1;
        p.o  = 1'b1;
        if (k < 32)       p.o = 1'b1;
        else if (k == 32) p.o = 1'b0;
        else if (k == 33) p.o = 1'b1;
        else if (k == 34) p.o = ~r.wr;
        else if (k == 35) p.o = r.wr;
        else if (k <= 40) p.o = r.phy[3'(40 - k)];
        else if (k <= 45) p.o = r.regn[3'(45 - k)];
        else if (!r.wr) begin
            p.oe = 1'b0;
            p.o  = 1'b0;
        end
        else if (k == 46) p.o = 1'b1;
        else if (k == 47) p.o = 1'b0;
        else              p.o = r.wdata[4'(63 - k)];
        return p;
    endfunction

endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int               DW      = 32,
    parameter int               DIV_W   = 4,
    parameter int               DIV_LSB = 2,
    parameter logic [DIV_W-1:0] DIV_RST = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [REG_AW-1:0]    addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic                 busy,
    input  logic                 rd_done,
    input  logic [DATA_BITS-1:0] rd_val,
    output mgmt_req_t            req,
    output logic [DIV_W-1:0]     div,
    output logic                 start
);
    localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

    logic                 go_q, dir_q, armed_q;
    logic [4:0]           phy_q, reg_q;
    logic [DATA_BITS-1:0] wd_q, rd_q;
    logic [DIV_W-1:0]     div_q;

    assign start = go_q & armed_q & ~busy;
    assign req   = '{wr: dir_q, phy: phy_q, regn: reg_q, wdata: wd_q};
    assign div   = div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q    <= 1'b0;
            dir_q   <= 1'b0;
            armed_q <= 1'b1;
            phy_q   <= '0;
            reg_q   <= '0;
            wd_q    <= '0;
            rd_q    <= '0;
            div_q   <= DIV_RST;
        end else begin
            if (start)      armed_q <= 1'b0;
            else if (!go_q) armed_q <= 1'b1;
            if (rd_done) rd_q <= rd_val;
            if (we) begin
                case (reg_sel_e'(addr))
                    SEL_CMD: begin
                        go_q  <= wdata[0];
                        dir_q <= wdata[1];
                    end
                    SEL_ADDR: begin
                        phy_q <= wdata[12:8];
                        reg_q <= wdata[4:0];
                    end
                    SEL_WDATA: wd_q  <= wdata[DATA_BITS-1:0];
                    SEL_CFG:   div_q <= wdata[DIV_MSB:DIV_LSB];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            SEL_CMD:   rdata[1:0] = {dir_q, go_q};
            SEL_ADDR: begin
                rdata[12:8] = phy_q;
                rdata[4:0]  = reg_q;
            end
            SEL_WDATA: rdata[DATA_BITS-1:0] = wd_q;
            SEL_RDATA: rdata[DATA_BITS-1:0] = rd_q;
            SEL_CFG:   rdata[DIV_MSB:DIV_LSB] = div_q;
            SEL_STAT:  rdata[0] = busy;
            default: ;
        endcase
    end

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(rd_q));

endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             run,
    output logic             phase,
    output logic             half_end
);
    logic [DIV_W-1:0] half_q, tick_q;
    logic             phase_q;

    assign half_end = run & (tick_q == half_q);
    assign phase    = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q  <= '0;
            tick_q  <= '0;
            phase_q <= 1'b0;
        end else if (load) begin
            half_q  <= div_in;
            tick_q  <= '0;
            phase_q <= 1'b0;
        end else if (run) begin
            if (half_end) begin
                tick_q  <= '0;
                phase_q <= ~phase_q;
            end else begin
                tick_q  <= tick_q + 1'b1;
            end
        end
    end

    // R4
    half_steady_chk: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) && !$past(half_end) && !$past(load) |-> $stable(phase));

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  mgmt_req_t            req,
    input  logic                 half_end,
    input  logic                 phase,
    input  logic                 mdio_i,
    output logic                 busy,
    output pin_t                 pin,
    output logic                 rd_done,
    output logic [DATA_BITS-1:0] rd_val
);
    logic                 busy_q;
    logic [IDX_W-1:0]     bit_q;
    mgmt_req_t            req_q;
    logic [DATA_BITS-1:0] sh_q;
    logic                 last;

    assign busy    = busy_q;
    assign last    = busy_q & half_end & phase & (bit_q == IDX_LAST);
    assign rd_done = last & ~req_q.wr;
    assign rd_val  = sh_q;
    assign pin     = busy_q ? frame_pin(bit_q, req_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            bit_q  <= '0;
            req_q  <= '0;
            sh_q   <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            bit_q  <= '0;
            req_q  <= req;
        end else if (busy_q && half_end) begin
            if (!phase) begin
                if (bit_q >= IDX_DATA) sh_q <= {sh_q[DATA_BITS-2:0], mdio_i};
            end else if (bit_q == IDX_LAST) begin
                busy_q <= 1'b0;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // R3
    frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ($past(bit_q) == IDX_LAST) && $past(phase));

    // R6
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && !req_q.wr && (bit_q >= IDX_TA) |-> !pin.oe);

endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
    import mdio_pkg::*;
#(
    parameter int               DW      = 32,
    parameter int               DIV_W   = 4,
    parameter int               DIV_LSB = 2,
    parameter logic [DIV_W-1:0] DIV_RST = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    mgmt_req_t            req;
    logic [DIV_W-1:0]     div;
    logic                 start, busy, phase, half_end, rd_done;
    logic [DATA_BITS-1:0] rd_val;
    pin_t                 pin;

    mdio_regs #(.DW(DW), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB), .DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst(rst), .we(host_we), .addr(host_addr), .wdata(host_wdata),
        .rdata(host_rdata), .busy(busy), .rd_done(rd_done), .rd_val(rd_val),
        .req(req), .div(div), .start(start)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst(rst), .load(start), .div_in(div), .run(busy),
        .phase(phase), .half_end(half_end)
    );

    mdio_shifter u_shift (
        .clk(clk), .rst(rst), .start(start), .req(req), .half_end(half_end),
        .phase(phase), .mdio_i(mdio_i), .busy(busy), .pin(pin),
        .rd_done(rd_done), .rd_val(rd_val)
    );

    assign mdc     = phase & busy;
    assign mdio_o  = pin.o;
    assign mdio_oe = pin.oe;

    // R5
    data_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o)) |-> !mdc);

endmodule

// File: tb/sim_mdio_mgmt.sv
module sim_mdio_mgmt;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = 3'd5;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #4 clk = ~clk;

    mdio_mgmt u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    typedef struct {bit mdc; bit oe; bit o; int idx;} ent_t;

    int checks = 0, errors = 0, mdc_hi = 0;
    bit finished = 0;

    // reference model state
    ent_t        q[$];
    ent_t        cur = '{0, 0, 0, 0};
    bit          cur_busy = 0, m_go = 0, m_dir = 0, m_armed = 1, m_twr = 0;
    logic [4:0]  m_phy = 0, m_reg = 0;
    logic [15:0] m_wd = 0, m_rd = 0, m_tval = 0, phy_val = 16'hA5C3;
    int          m_div = 13;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic build(bit wr, logic [4:0] p, logic [4:0] r, logic [15:0] d, int h);
        logic [63:0] f;
        f = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
        for (int b = 0; b < 64; b++) begin
            bit oe;
            oe = !(!wr && b >= 46);
            for (int ph = 0; ph < 2; ph++)
                for (int t = 0; t < h; t++)
                    q.push_back('{ph[0], oe, oe ? f[63-b] : 1'b0, b});
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            cur = '{0, 0, 0, 0}; cur_busy = 0; m_go = 0; m_dir = 0; m_armed = 1;
            m_phy = 0; m_reg = 0; m_wd = 0; m_rd = 0; m_div = 13;
        end else begin
            bit st;
            st = !cur_busy && m_go && m_armed;
            if (cur_busy) begin
                if (q.size() > 0) cur = q.pop_front();
                else begin
                    cur_busy = 0;
                    cur = '{0, 0, 0, 0};
                    if (!m_twr) m_rd = m_tval;
                end
            end else if (st) begin
                build(m_dir, m_phy, m_reg, m_wd, m_div + 1);
                m_twr = m_dir; m_tval = phy_val;
                cur = q.pop_front(); cur_busy = 1;
            end
            if (st) m_armed = 0;
            else if (!m_go) m_armed = 1;
            if (host_we) begin
                case (host_addr)
                    3'd0: begin m_go = host_wdata[0]; m_dir = host_wdata[1]; end
                    3'd1: begin m_phy = host_wdata[12:8]; m_reg = host_wdata[4:0]; end
                    3'd2: m_wd = host_wdata[15:0];
                    3'd4: m_div = int'(host_wdata[5:2]);
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, then PHY input drive
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            check(mdc == cur.mdc, "R4 mdc", {31'b0, mdc}, {31'b0, cur.mdc});
            check(mdio_oe == cur.oe, "R6 mdio_oe", {31'b0, mdio_oe}, {31'b0, cur.oe});
            if (cur.oe) check(mdio_o == cur.o, "R5 mdio_o", {31'b0, mdio_o}, {31'b0, cur.o});
            if (host_addr == 3'd5 && !host_we)
                check(host_rdata[0] == cur_busy, "R3 busy", host_rdata, {31'b0, cur_busy});
            if (mdc) mdc_hi++;
        end
        mdio_i = (cur_busy && cur.idx >= 48) ? m_tval[63 - cur.idx] : 1'b1;
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_addr = 3'd5;
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        host_addr = a;
        #1;
        check(host_rdata == exp, tag, host_rdata, exp);
        @(negedge clk);
        host_addr = 3'd5;
    endtask

    task automatic wait_txn();
        do begin @(posedge clk); #3; end while (!cur_busy);
        do begin @(posedge clk); #3; end while (cur_busy);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk); #1;
        check(mdc == 0 && mdio_oe == 0, "R1 pins", {30'b0, mdc, mdio_oe}, 32'h0);
        rd(3'd4, 32'h34, "R1 cfg");
        rd(3'd3, 32'h0, "R1 rdata");
        rd(3'd5, 32'h0, "R1 status");
        // R2 map and masking
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, 32'h1F1F, "R2 addr mask");
        wr(3'd2, 32'hFFFF_1234);
        rd(3'd2, 32'h1234, "R2 wdata");
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, 32'h3C, "R2 cfg");
        wr(3'd3, 32'h0000_BEEF);
        rd(3'd3, 32'h0, "R2 rdata read-only");
        wr(3'd0, 32'hFFFF_FFFE);
        rd(3'd0, 32'h2, "R2 cmd");
        // read frame, divider 1
        wr(3'd4, 32'h4);
        wr(3'd1, (32'h15 << 8) | 32'h0A);
        phy_val = 16'hA5C3;
        wr(3'd0, 32'h1);
        wait_txn();
        rd(3'd3, 32'hA5C3, "R7 read capture");
        // R8 no restart while start held
        repeat (20) @(negedge clk);
        rd(3'd5, 32'h0, "R8 held start no restart");
        wr(3'd0, 32'h0);
        // write frame, divider 0, read-data must stay
        wr(3'd4, 32'h0);
        wr(3'd2, 32'h3C5A);
        wr(3'd1, (32'h03 << 8) | 32'h11);
        wr(3'd0, 32'h3);
        wait_txn();
        rd(3'd3, 32'hA5C3, "R7 write keeps rdata");
        wr(3'd0, 32'h0);
        // R8 pending start meets frame end; R9 divider changed mid-frame
        wr(3'd4, 32'h4);
        phy_val = 16'h0F81;
        wr(3'd0, 32'h1);
        do begin @(posedge clk); #3; end while (!cur_busy);
        mdc_hi = 0;
        wr(3'd0, 32'h0);
        wr(3'd4, 32'hC);
        wr(3'd0, 32'h1);
        do begin @(posedge clk); #3; end while (cur_busy);
        check(host_rdata[0] == 1'b0, "R8 one idle cycle", host_rdata, 32'h0);
        check(mdc_hi == 128, "R9 divider captured", mdc_hi, 32'd128);
        @(posedge clk); #3;
        check(host_rdata[0] == 1'b1, "R8 pending start", host_rdata, 32'h1);
        mdc_hi = 0;
        wait_txn();
        check(mdc_hi == 256, "R9 new divider used", mdc_hi, 32'd256);
        rd(3'd3, 32'h0F81, "R7 second read");
        wr(3'd0, 32'h0);
        // default-rate write frame
        wr(3'd4, 32'h34);
        wr(3'd0, 32'h3);
        mdc_hi = 0;
        wait_txn();
        check(mdc_hi == 64 * 14, "R4 default rate", mdc_hi, 64 * 14);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule